// File: doc/BRIEF.md
# Receiver Wake-Up and Precharge Sequencer

This block takes a radio receiver from power-down to the point where its demodulated data can be trusted. When a receive request arrives it waits a fixed number of time ticks, long enough for the reference oscillator to start and the frequency synthesizer to settle. Only then does it look at the synthesizer lock indicator. A high lock reading is taken as proof of lock. A low reading is not taken as proof of anything, so the block keeps sampling until a timeout. If the timeout expires it raises a failure flag and carries on.

After the lock check the sequencer takes one of two paths. If precharge is enabled, it drives the demodulator fast-settling request for a minimum number of bit periods and declares data valid when it releases that request. If precharge is disabled, it waits a longer, fixed number of bit periods before it declares data valid. A retune pulse marks each reprogramming of the synthesizer, for example a switch between receive and transmit. The pulse clears the lock status and restarts the sequence with a short, synthesizer-only settle. Dropping the receive enable returns the sequencer to idle from any state.

Top module: `rx_wake_seq`

## Requirements
- R1: After reset, state_o reads idle and pch_req, lock_ok, lock_fail and data_valid are low. The state codes are: idle 0, settling 1, lock_check 2, precharge 3, wait_valid 4, valid 5.
- R2: With rx_en high in idle, the next clock edge enters settling. Settling lasts XTAL_TICKS+SYNTH_TICKS (default 8) tick pulses, and the last of these pulses moves the state to lock_check. Tick pulses have no effect while the sequencer is idle.
- R3: lock_in passes through a two-stage synchronizer. In lock_check, a synchronized high lock sets lock_ok, and the sequencer leaves lock_check on the next clock edge. A change on lock_in therefore takes effect on the third rising edge after it.
- R4: In lock_check, a low lock is not conclusive and is sampled again. If lock is still low on the LOCK_TIMEOUT-th tick (default 4), lock_fail is set, lock_ok stays low, and the sequence continues. lock_ok and lock_fail are never high together.
- R5: If pch_en is high when lock_check ends, the state becomes precharge and pch_req is high. On the PCH_BITS-th bit_tick (default 5) the state becomes valid, pch_req falls and data_valid rises in the same cycle. Bit ticks have no effect outside the precharge and wait_valid states.
- R6: If pch_en is low when lock_check ends, the state becomes wait_valid and pch_req stays low. On the NOPCH_BITS-th bit_tick (default 30) the state becomes valid and data_valid rises.
- R7: A retune pulse with rx_en high in any state other than idle moves the sequencer to settling on the next edge and clears lock_ok, lock_fail, pch_req and data_valid. This settle lasts only SYNTH_TICKS (default 2) ticks.
- R8: rx_en low in any state returns the sequencer to idle on the next edge with all outputs low. A low rx_en takes priority over a retune pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive request; low means power-down |
| pch_en | input | 1 | Use demodulator precharge on this start |
| retune | input | 1 | One-cycle pulse when the synthesizer is reprogrammed |
| tick | input | 1 | One-cycle time base pulse (e.g. 1 ms) |
| bit_tick | input | 1 | One-cycle pulse per received bit period |
| lock_in | input | 1 | Asynchronous synthesizer lock indicator |
| pch_req | output | 1 | Demodulator fast-settling request |
| lock_ok | output | 1 | Lock confirmed during lock check |
| lock_fail | output | 1 | Lock check timed out without a high reading |
| data_valid | output | 1 | Received data may be used |
| state_o | output | 3 | Current sequencer state code |

## Verification
The bench sweeps every combination of precharge on or off with three lock behaviours: lock already high, lock never high, and lock rising partway through the retry window. The first lock behaviour separates a conclusive lock from a timeout. The last one shows that sampling continues after a low reading, and it also fixes the synchronizer latency. For each path, tick and bit_tick counts are stopped one pulse short of the limit and then at the limit, which exposes off-by-one errors in each counter and a wrong choice of limit. Separate runs cover the retune restart and its shorter settle, power-down from precharge, and the case where power-down and retune arrive in the same cycle.

// File: rtl/wake_pkg.sv
// Shared state encoding for the receiver wake-up sequencer.
// Assumes: codes are observed externally on state_o and must stay fixed.
package wake_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_LCHK   = 3'd2,
        ST_PCH    = 3'd3,
        ST_WAITV  = 3'd4,
        ST_VALID  = 3'd5
    } wake_state_t;
endpackage

// File: rtl/wake_sync.sv
// Multi-stage synchronizer for an asynchronous level input.
// Assumes: STAGES >= 2; output lags the input by STAGES clock edges.
module wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/wake_cnt.sv
// Event counter that flags the event that reaches a given limit.
// Assumes: limit >= 1; the owner clears it on each phase change.
module wake_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    // Count qualified events; a clear wins over an event.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (adv) cnt <= cnt + 1'b1;
    end

    assign hit = adv && (cnt == limit - 1'b1);
endmodule

// File: rtl/wake_fsm.sv
// Wake-up state machine: settle, lock check, precharge or plain wait, valid.
// Assumes: counter hits arrive from wake_cnt instances cleared by phase_clr.
module wake_fsm
    import wake_pkg::*;
#(
    parameter int TW          = 4,
    parameter int BW          = 5,
    parameter int XTAL_TICKS  = 6,
    parameter int SYNTH_TICKS = 2,
    parameter int LOCK_TIMEOUT = 4,
    parameter int PCH_BITS    = 5,
    parameter int NOPCH_BITS  = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          retune,
    input  logic          pch_en,
    input  logic          lock_s,
    input  logic          tick,
    input  logic          bit_tick,
    input  logic          tick_hit,
    input  logic          bit_hit,
    output wake_state_t   st,
    output logic          phase_clr,
    output logic          tick_adv,
    output logic          bit_adv,
    output logic [TW-1:0] tick_limit,
    output logic [BW-1:0] bit_limit,
    output logic          lock_ok,
    output logic          lock_fail
);
    localparam logic [TW-1:0] FULL_SETTLE  = TW'(XTAL_TICKS + SYNTH_TICKS);
    localparam logic [TW-1:0] SHORT_SETTLE = TW'(SYNTH_TICKS);
    localparam logic [TW-1:0] LCHK_LIMIT   = TW'(LOCK_TIMEOUT);
    localparam logic [BW-1:0] PCH_LIMIT    = BW'(PCH_BITS);
    localparam logic [BW-1:0] NOPCH_LIMIT  = BW'(NOPCH_BITS);

    wake_state_t nxt;
    logic        short_settle;
    logic        restart;

    assign restart = rx_en && retune && (st != ST_IDLE);

    // Next-state decision; power-down first, then retune, then progress.
    always_comb begin
        nxt = st;
        if (!rx_en) begin
            nxt = ST_IDLE;
        end else if (restart) begin
            nxt = ST_SETTLE;
        end else begin
            unique case (st)
                ST_IDLE:   nxt = ST_SETTLE;
                ST_SETTLE: if (tick_hit) nxt = ST_LCHK;
                ST_LCHK:   if (lock_s || tick_hit) nxt = pch_en ? ST_PCH : ST_WAITV;
                ST_PCH,
                ST_WAITV:  if (bit_hit) nxt = ST_VALID;
                default:   nxt = st;
            endcase
        end
    end

    // Counter control derived from the current phase.
    always_comb begin
        phase_clr  = (nxt != st) || restart;
        tick_adv   = tick && ((st == ST_SETTLE) || (st == ST_LCHK));
        bit_adv    = bit_tick && ((st == ST_PCH) || (st == ST_WAITV));
        tick_limit = (st == ST_LCHK) ? LCHK_LIMIT
                   : (short_settle ? SHORT_SETTLE : FULL_SETTLE);
        bit_limit  = (st == ST_PCH) ? PCH_LIMIT : NOPCH_LIMIT;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Remember whether the running settle follows a retune.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en)   short_settle <= 1'b0;
        else if (restart)       short_settle <= 1'b1;
        else if (st == ST_IDLE) short_settle <= 1'b0;
    end

    // Lock status flags, cleared by power-down or reprogramming.
    always_ff @(posedge clk) begin
        if (!rst_n || !rx_en || restart) begin
            lock_ok   <= 1'b0;
            lock_fail <= 1'b0;
        end else if (st == ST_LCHK) begin
            if (lock_s)        lock_ok   <= 1'b1;
            else if (tick_hit) lock_fail <= 1'b1;
        end
    end
endmodule

// File: rtl/rx_wake_seq.sv
// Top of the receiver wake-up sequencer: synchronizer, two phase counters, FSM.
// Assumes: tick and bit_tick are single-cycle pulses in the clk domain.
module rx_wake_seq
    import wake_pkg::*;
#(
    parameter int XTAL_TICKS   = 6,
    parameter int SYNTH_TICKS  = 2,
    parameter int LOCK_TIMEOUT = 4,
    parameter int PCH_BITS     = 5,
    parameter int NOPCH_BITS   = 30,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       pch_en,
    input  logic       retune,
    input  logic       tick,
    input  logic       bit_tick,
    input  logic       lock_in,
    output logic       pch_req,
    output logic       lock_ok,
    output logic       lock_fail,
    output logic       data_valid,
    output logic [2:0] state_o
);
    localparam int TMAX = (XTAL_TICKS + SYNTH_TICKS > LOCK_TIMEOUT) ?
                          XTAL_TICKS + SYNTH_TICKS : LOCK_TIMEOUT;
    localparam int BMAX = (PCH_BITS > NOPCH_BITS) ? PCH_BITS : NOPCH_BITS;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int BW   = $clog2(BMAX + 1);

    wake_state_t   st;
    logic          lock_s;
    logic          phase_clr, tick_adv, bit_adv, tick_hit, bit_hit;
    logic [TW-1:0] tick_limit;
    logic [BW-1:0] bit_limit;

    wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(lock_in), .q(lock_s)
    );

    wake_cnt #(.W(TW)) u_tick_cnt (
        .clk(clk), .rst_n(rst_n), .clr(phase_clr), .adv(tick_adv),
        .limit(tick_limit), .hit(tick_hit)
    );

    wake_cnt #(.W(BW)) u_bit_cnt (
        .clk(clk), .rst_n(rst_n), .clr(phase_clr), .adv(bit_adv),
        .limit(bit_limit), .hit(bit_hit)
    );

    wake_fsm #(
        .TW(TW), .BW(BW), .XTAL_TICKS(XTAL_TICKS), .SYNTH_TICKS(SYNTH_TICKS),
        .LOCK_TIMEOUT(LOCK_TIMEOUT), .PCH_BITS(PCH_BITS), .NOPCH_BITS(NOPCH_BITS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .retune(retune),
        .pch_en(pch_en), .lock_s(lock_s), .tick(tick), .bit_tick(bit_tick),
        .tick_hit(tick_hit), .bit_hit(bit_hit), .st(st),
        .phase_clr(phase_clr), .tick_adv(tick_adv), .bit_adv(bit_adv),
        .tick_limit(tick_limit), .bit_limit(bit_limit),
        .lock_ok(lock_ok), .lock_fail(lock_fail)
    );

    assign pch_req    = (st == ST_PCH);
    assign data_valid = (st == ST_VALID);
    assign state_o    = st;
endmodule

// File: rtl/wake_chk.sv
// Property checker for rx_wake_seq, attached through bind.
// Assumes: only top-level ports are observed.
module wake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       retune,
    input logic       pch_req,
    input logic       lock_ok,
    input logic       lock_fail,
    input logic       data_valid,
    input logic [2:0] state_o
);
    a_r3_lock_from_check: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_ok) |-> ($past(state_o) == 3'd2));

    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lock_ok && lock_fail));

    a_r5_valid_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_valid) |-> ($past(state_o) == 3'd3 || $past(state_o) == 3'd4));

    a_r5_pch_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(pch_req && data_valid));

    a_r7_retune_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && retune && state_o != 3'd0) |=>
        (state_o == 3'd1 && !lock_ok && !lock_fail && !data_valid && !pch_req));

    a_r8_powerdown: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state_o == 3'd0 && !pch_req && !data_valid && !lock_ok && !lock_fail));
endmodule

bind rx_wake_seq wake_chk u_wake_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .retune(retune),
    .pch_req(pch_req), .lock_ok(lock_ok), .lock_fail(lock_fail),
    .data_valid(data_valid), .state_o(state_o)
);

// File: tb/test_rx_wake_seq.sv
module test_rx_wake_seq;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE  = 8;
    localparam int SHORT   = 2;
    localparam int TIMEOUT = 4;
    localparam int PCHB    = 5;
    localparam int NOPCHB  = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, pch_en = 1'b0, retune = 1'b0;
    logic tick = 1'b0, bit_tick = 1'b0, lock_in = 1'b0;
    logic pch_req, lock_ok, lock_fail, data_valid;
    logic [2:0] state_o;
    int n_chk = 0;
    int n_fail = 0;

    rx_wake_seq i_rx_wake_seq (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .pch_en(pch_en),
        .retune(retune), .tick(tick), .bit_tick(bit_tick), .lock_in(lock_in),
        .pch_req(pch_req), .lock_ok(lock_ok), .lock_fail(lock_fail),
        .data_valid(data_valid), .state_o(state_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_bit();
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    // lk: 0 = lock high early, 1 = never high, 2 = rises after two ticks
    task automatic run_case(input int pch, input int lk);
        int exp_st;
        int nb;
        exp_st = pch ? 3 : 4;
        nb = pch ? PCHB : NOPCHB;
        rx_en = 1'b0; pch_en = pch[0]; lock_in = (lk == 0);
        step(); step(); step();
        check("R8 idle before start", state_o, 0);
        rx_en = 1'b1;
        step();
        check("R2 enter settling", state_o, 1);
        repeat (3) do_bit();
        check("R5 bit ticks ignored in settling", state_o, 1);
        repeat (SETTLE - 1) do_tick();
        check("R2 still settling one tick short", state_o, 1);
        do_tick();
        check("R2 lock_check after settle", state_o, 2);
        if (lk == 0) begin
            step();
            check("R3 leave lock_check", state_o, exp_st);
            check("R3 lock_ok", lock_ok, 1);
            check("R4 no fail on lock", lock_fail, 0);
        end else if (lk == 1) begin
            repeat (TIMEOUT - 1) do_tick();
            check("R4 still checking", state_o, 2);
            check("R4 no fail before timeout", lock_fail, 0);
            do_tick();
            check("R4 continue after timeout", state_o, exp_st);
            check("R4 lock_fail", lock_fail, 1);
            check("R4 lock_ok low", lock_ok, 0);
        end else begin
            repeat (2) do_tick();
            lock_in = 1'b1;
            step(); step();
            check("R3 sync latency", state_o, 2);
            step();
            check("R3 late lock accepted", state_o, exp_st);
            check("R3 late lock_ok", lock_ok, 1);
        end
        check(pch ? "R5 pch_req high" : "R6 pch_req low", pch_req, pch);
        repeat (nb - 1) do_bit();
        check(pch ? "R5 one bit short" : "R6 one bit short", state_o, exp_st);
        check(pch ? "R5 not yet valid" : "R6 not yet valid", data_valid, 0);
        do_bit();
        check(pch ? "R5 valid state" : "R6 valid state", state_o, 5);
        check(pch ? "R5 data_valid" : "R6 data_valid", data_valid, 1);
        check(pch ? "R5 pch released" : "R6 pch low", pch_req, 0);
    endtask

    initial begin
        repeat (3) step();
        check("R1 reset state", state_o, 0);
        check("R1 reset pch_req", pch_req, 0);
        check("R1 reset data_valid", data_valid, 0);
        check("R1 reset lock flags", {lock_ok, lock_fail}, 0);
        rst_n = 1'b1;
        step();
        repeat (10) do_tick();
        check("R2 ticks ignored while idle", state_o, 0);

        for (int p = 0; p < 2; p++) begin
            for (int l = 0; l < 3; l++) run_case(p, l);
        end

        // Retune from valid: short settle, status cleared (R7)
        pch_en = 1'b1; lock_in = 1'b1;
        retune = 1'b1;
        step();
        retune = 1'b0;
        check("R7 back to settling", state_o, 1);
        check("R7 lock_ok cleared", lock_ok, 0);
        check("R7 data_valid cleared", data_valid, 0);
        do_tick();
        check("R7 short settle one short", state_o, 1);
        do_tick();
        check("R7 short settle done", state_o, 2);
        step();
        check("R7 precharge after retune", pch_req, 1);

        // Power-down from precharge (R8)
        rx_en = 1'b0;
        step();
        check("R8 idle after power-down", state_o, 0);
        check("R8 pch_req cleared", pch_req, 0);
        check("R8 lock_ok cleared", lock_ok, 0);

        // Power-down beats retune (R8)
        rx_en = 1'b1;
        step();
        check("R2 settling again", state_o, 1);
        rx_en = 1'b0; retune = 1'b1;
        step();
        retune = 1'b0;
        check("R8 priority over retune", state_o, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule